// File: doc/BRIEF.md
# GPIO interrupt cause controller

This block turns 32 general-purpose input lines into four grouped interrupt requests. Each line first passes through a synchronizer. A per-line polarity bit then inverts it or passes it through. The result is the line's data-in value, and it feeds two separate interrupt paths.

The level path uses the data-in bit directly as its request, qualified by a level mask. The edge path records a 0-to-1 change of data-in in a sticky cause bit, which software clears by writing zero to it. That cause bit is qualified by its own edge mask. For each line the two masked terms are OR-ed together. Each run of eight consecutive lines is then OR-reduced onto one summary output.

A direction register marks which lines are inputs. Lines not marked as inputs read as zero and can raise nothing. Software drives everything through a small address / write-enable / data port with registered read data.

Top module: `gpio_irq_cause`

## Requirements
- R1: The data-in register (address 0) reads the pin value XOR the polarity bit. A pin change is visible in data-in two clock edges after it is applied, because of the two-flop synchronizer.
- R2: The level request of a line is data-in AND level-mask (address 3) AND direction. It is not latched: it drops as soon as data-in drops.
- R3: An edge-cause bit (address 5) is set on a 0-to-1 transition of data-in. Polarity 0 therefore catches rising pins and polarity 1 catches falling pins. Once set, the bit stays set when the pin returns.
- R4: The edge-mask register (address 4) gates only the contribution of a cause bit to the summary outputs. A cause bit is still recorded while its mask bit is 0.
- R5: Summary output bit g (g = 0..3) is the OR, over lines 8g to 8g+7, of the masked level term OR the masked edge term. The outputs are combinational from registered state.
- R6: Reset clears polarity, direction, both masks, edge cause and the synchronizers. After reset all summary outputs and all register reads are 0.
- R7: A write to the edge-cause register clears each bit where the written data is 0 and keeps each bit where it is 1. An edge that arrives in the same cycle as the clear wins, so the bit ends up set.
- R8: Changing a polarity bit with the pin steady never sets that line's edge-cause bit.
- R9: Direction bit 1 marks a line as an input. A line with direction 0 reads 0 in data-in, produces no level request and never sets its edge-cause bit.
- R10: The register map is: 0 data-in (read-only, writes ignored), 1 polarity, 2 direction, 3 level mask, 4 edge mask, 5 edge cause. Addresses 6 and 7 read 0. Read data appears on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | 32 | Asynchronous GPIO line inputs |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| irqGroup | output | 4 | One summary interrupt per group of eight lines |

## Verification
The bench sweeps every line through the level path and the rising-edge path, so that each line is checked against its own group output. A design that routed a line into the wrong group, or that latched the level path, would fail this sweep.

Falling-edge detection under inverted polarity is checked on one line per group. A polarity flip with steady pins must leave the cause register empty; a design that compared against the pre-inversion history would fail here.

The bench also times a write-zero-to-clear to land in the same cycle as a new edge. A design that lets the clear take priority would lose that event.

Lines with direction 0 must stay silent on both paths, and an edge-masked cause bit must be recorded yet hidden from the outputs until its mask bit is set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA_IN   = 3'd0,
    SEL_POLARITY  = 3'd1,
    SEL_DIRECTION = 3'd2,
    SEL_LVL_MASK  = 3'd3,
    SEL_EDGE_MASK = 3'd4,
    SEL_CAUSE     = 3'd5
  } regSel_e;

  typedef struct packed {
    logic    wrPol;
    logic    wrDir;
    logic    wrLvl;
    logic    wrEdgeMask;
    logic    wrCause;
    logic    rdValid;
    regSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);
  regSel_e sel;

  always_comb begin
    sel                = regSel_e'(regAddr);
    strobes            = '0;
    strobes.rdSel      = sel;
    strobes.rdValid    = (regAddr <= ADDR_W'(SEL_CAUSE));
    strobes.wrPol      = regWe && (sel == SEL_POLARITY);
    strobes.wrDir      = regWe && (sel == SEL_DIRECTION);
    strobes.wrLvl      = regWe && (sel == SEL_LVL_MASK);
    strobes.wrEdgeMask = regWe && (sel == SEL_EDGE_MASK);
    strobes.wrCause    = regWe && (sel == SEL_CAUSE);
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_LINES   = 32,
  parameter  int GROUP_SIZE  = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_GROUPS  = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  pinIn,
  input  logic [NUM_LINES-1:0]  wrData,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_LINES-1:0]  rdData,
  output logic [NUM_LINES-1:0]  dataIn,
  output logic [NUM_LINES-1:0]  polQ,
  output logic [NUM_LINES-1:0]  dirQ,
  output logic [NUM_LINES-1:0]  lvlMaskQ,
  output logic [NUM_LINES-1:0]  edgeMaskQ,
  output logic [NUM_LINES-1:0]  causeQ,
  output logic [NUM_GROUPS-1:0] irqGroup
);
  logic [NUM_LINES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_LINES-1:0] histQ;
  logic [NUM_LINES-1:0] pinNow, prevView, edgeHit, causeNext;
  logic [NUM_LINES-1:0] lineReq, rdNext;

  // Input synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
      histQ <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      histQ <= syncStage[SYNC_STAGES-1];
    end
  end

  // Both current and previous views use today's polarity, so a polarity
  // flip with a steady pin yields no transition.
  always_comb begin
    pinNow   = syncStage[SYNC_STAGES-1];
    dataIn   = pinNow ^ polQ;
    prevView = histQ ^ polQ;
    edgeHit  = dataIn & ~prevView & dirQ;
    causeNext = (strobes.wrCause ? (causeQ & wrData) : causeQ) | edgeHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      polQ      <= '0;
      dirQ      <= '0;
      lvlMaskQ  <= '0;
      edgeMaskQ <= '0;
      causeQ    <= '0;
    end else begin
      if (strobes.wrPol)      polQ      <= wrData;
      if (strobes.wrDir)      dirQ      <= wrData;
      if (strobes.wrLvl)      lvlMaskQ  <= wrData;
      if (strobes.wrEdgeMask) edgeMaskQ <= wrData;
      causeQ <= causeNext;
    end
  end

  assign lineReq = (dataIn & lvlMaskQ & dirQ) | (causeQ & edgeMaskQ);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign irqGroup[g] = |lineReq[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdValid) begin
      case (strobes.rdSel)
        SEL_DATA_IN:   rdNext = dataIn & dirQ;
        SEL_POLARITY:  rdNext = polQ;
        SEL_DIRECTION: rdNext = dirQ;
        SEL_LVL_MASK:  rdNext = lvlMaskQ;
        SEL_EDGE_MASK: rdNext = edgeMaskQ;
        SEL_CAUSE:     rdNext = causeQ;
        default:       rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_LINES   = 32,
  parameter  int GROUP_SIZE  = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NUM_GROUPS  = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LINES-1:0]  pinIn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWe,
  input  logic [NUM_LINES-1:0]  regWrData,
  output logic [NUM_LINES-1:0]  regRdData,
  output logic [NUM_GROUPS-1:0] irqGroup
);
  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] dataIn, polQ, dirQ, lvlMaskQ, edgeMaskQ, causeQ;

  gpio_irq_ctrl u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  gpio_irq_dp #(
    .NUM_LINES   (NUM_LINES),
    .GROUP_SIZE  (GROUP_SIZE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .pinIn     (pinIn),
    .wrData    (regWrData),
    .strobes   (strobes),
    .rdData    (regRdData),
    .dataIn    (dataIn),
    .polQ      (polQ),
    .dirQ      (dirQ),
    .lvlMaskQ  (lvlMaskQ),
    .edgeMaskQ (edgeMaskQ),
    .causeQ    (causeQ),
    .irqGroup  (irqGroup)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_LINES  = 32,
  parameter int NUM_GROUPS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  regWe,
  input logic [2:0]            regAddr,
  input logic [NUM_LINES-1:0]  dataIn,
  input logic [NUM_LINES-1:0]  dirQ,
  input logic [NUM_LINES-1:0]  lvlMaskQ,
  input logic [NUM_LINES-1:0]  edgeMaskQ,
  input logic [NUM_LINES-1:0]  causeQ,
  input logic [NUM_GROUPS-1:0] irqGroup
);
  // R7
  cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWe && regAddr == 3'd5) |=> ((causeQ & $past(causeQ)) == $past(causeQ)));

  // R9
  cause_dir_chk: assert property (@(posedge clk) disable iff (rst)
    ((causeQ & ~$past(causeQ) & ~$past(dirQ)) == '0));

  // R3
  cause_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((causeQ & ~$past(causeQ) & ~$past(dataIn)) == '0));

  // R5
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lvlMaskQ == '0 && edgeMaskQ == '0) |-> (irqGroup == '0));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (causeQ == '0 && lvlMaskQ == '0 && edgeMaskQ == '0 && dirQ == '0));
endmodule

bind gpio_irq_cause gpio_irq_chk #(
  .NUM_LINES  (NUM_LINES),
  .NUM_GROUPS (NUM_GROUPS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .dataIn    (dataIn),
  .dirQ      (dirQ),
  .lvlMaskQ  (lvlMaskQ),
  .edgeMaskQ (edgeMaskQ),
  .causeQ    (causeQ),
  .irqGroup  (irqGroup)
);

// File: tb/sim_gpio_irq_cause.sv
`timescale 1ns/1ps
module sim_gpio_irq_cause;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pinIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  irqGroup;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_irq_cause u0 (
    .clk(clk), .rst(rst), .pinIn(pinIn), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .irqGroup(irqGroup)
  );

  function automatic logic [31:0] pat(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h5BD1E995 >> k);
  endfunction

  function automatic logic [3:0] grp(input logic [31:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = (((v >> (8 * g)) & 32'hFF) != 0);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    @(posedge clk); @(negedge clk);
    d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R6 reset state
    check("R6 irq", {28'd0, irqGroup}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); check("R6 reg", rv, 32'd0);
    end

    // R10 register map
    for (int a = 1; a < 5; a++) begin
      wr(3'(a), pat(a)); rd(3'(a), rv); check("R10 readback", rv, pat(a));
      wr(3'(a), 32'd0);
    end
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, rv); check("R10 addr6", rv, 32'd0);
    rd(3'd7, rv); check("R10 addr7", rv, 32'd0);
    wr(3'd2, 32'hFFFF_FFFF);
    pinIn = 32'h0000_00F0; settle();
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, rv); check("R10 datain ro", rv, 32'h0000_00F0);

    // R1 data-in = pin ^ polarity
    for (int k = 0; k < 6; k++) begin
      pinIn = pat(k + 11); wr(3'd1, pat(k + 7)); settle();
      rd(3'd0, rv); check("R1 datain", rv, pat(k + 11) ^ pat(k + 7));
    end
    // R1 two-edge latency
    wr(3'd1, 32'd0); pinIn = 32'd0; settle();
    pinIn = 32'h0000_0100;
    wr(3'd3, 32'h0000_0100);
    check("R1 latency", {28'd0, irqGroup}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1 latency", {28'd0, irqGroup}, 32'h2);

    // R9 partial direction on data-in
    wr(3'd3, 32'd0);
    pinIn = pat(3); wr(3'd1, pat(4)); wr(3'd2, 32'h00FF_F00F); settle();
    rd(3'd0, rv); check("R9 datain dir", rv, (pat(3) ^ pat(4)) & 32'h00FF_F00F);

    wr(3'd1, 32'd0); wr(3'd2, 32'hFFFF_FFFF); pinIn = 32'd0; settle(); wr(3'd5, 32'd0);

    // R2 R5 level sweep per line
    wr(3'd4, 32'd0);
    for (int i = 0; i < 32; i++) begin
      wr(3'd3, 32'd1 << i);
      pinIn = 32'd1 << i; settle();
      check("R5 group", {28'd0, irqGroup}, 32'd1 << (i / 8));
      pinIn = 32'd0; settle();
      check("R2 unlatched", {28'd0, irqGroup}, 32'd0);
    end
    for (int k = 0; k < 6; k++) begin
      wr(3'd3, pat(k)); pinIn = pat(k + 3); settle();
      check("R5 pattern", {28'd0, irqGroup}, {28'd0, grp(pat(k) & pat(k + 3))});
    end
    wr(3'd3, 32'd0); pinIn = 32'd0; settle(); wr(3'd5, 32'd0);

    // R3 rising sweep
    wr(3'd4, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      pinIn = 32'd1 << i; settle();
      rd(3'd5, rv); check("R3 rising", rv, 32'd1 << i);
      check("R3 irq", {28'd0, irqGroup}, 32'd1 << (i / 8));
      pinIn = 32'd0; settle();
      rd(3'd5, rv); check("R3 sticky", rv, 32'd1 << i);
      wr(3'd5, 32'd0);
    end

    // R3 falling with polarity 1
    wr(3'd1, 32'hFFFF_FFFF); pinIn = 32'hFFFF_FFFF; settle(); wr(3'd5, 32'd0);
    for (int j = 0; j < 4; j++) begin
      pinIn = ~(32'd1 << (9 * j)); settle();
      rd(3'd5, rv); check("R3 falling", rv, 32'd1 << (9 * j));
      pinIn = 32'hFFFF_FFFF; settle();
      rd(3'd5, rv); check("R3 rise ignored pol1", rv, 32'd1 << (9 * j));
      wr(3'd5, 32'd0);
    end

    // R4 edge mask gates only the output
    wr(3'd1, 32'd0); pinIn = 32'd0; settle(); wr(3'd5, 32'd0);
    wr(3'd4, 32'd0);
    pinIn = 32'h0000_0020; settle();
    rd(3'd5, rv); check("R4 recorded", rv, 32'h0000_0020);
    check("R4 masked irq", {28'd0, irqGroup}, 32'd0);
    wr(3'd4, 32'h0000_0020);
    check("R4 unmasked irq", {28'd0, irqGroup}, 32'h1);

    // R7 write-zero-to-clear
    pinIn = 32'h0101_0121; settle();
    rd(3'd5, rv); check("R7 collect", rv, 32'h0101_0121);
    wr(3'd5, 32'h0100_0020);
    rd(3'd5, rv); check("R7 partial clear", rv, 32'h0100_0020);
    pinIn = 32'd0; settle(); wr(3'd5, 32'd0);
    pinIn = 32'h0000_0008; settle();
    pinIn = 32'h0000_1008;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(3'd5, 32'd0);
    rd(3'd5, rv); check("R7 set wins", rv, 32'h0000_1000);

    // R8 polarity flip alone
    pinIn = pat(2); settle(); wr(3'd5, 32'd0);
    for (int k = 0; k < 5; k++) begin
      wr(3'd1, pat(k + 20)); settle();
      rd(3'd5, rv); check("R8 pol flip", rv, 32'd0);
    end

    // R9 non-input line silent
    wr(3'd1, 32'd0); pinIn = 32'd0; settle(); wr(3'd5, 32'd0);
    wr(3'd2, ~(32'd1 << 7)); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    pinIn = 32'd1 << 7; settle();
    rd(3'd5, rv); check("R9 no cause", rv, 32'd0);
    check("R9 no level", {28'd0, irqGroup}, 32'd0);
    pinIn = 32'h0000_0180; settle();
    check("R9 neighbour", {28'd0, irqGroup}, 32'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule